// File: doc/BRIEF.md
# Flash Write Status Reporter

This block stands beside the storage array of a NOR-style flash model. It times the device's internal write operations (byte program, sector erase, block erase, whole-chip erase) in clock cycles. It also decides what byte a host read returns while such an operation runs. The command decoder in front of it issues one-cycle start pulses. The array behind it supplies `array_data` for the location being read. The reporter either passes that byte through or replaces it with a status byte. A status byte carries a polling bit (bit 7), a per-read toggle bit (bit 6) and a second toggle bit (bit 2).

Erase can be suspended. The host can then read other regions, and it can program bytes outside the suspended sector or block. Reads that hit the suspended region return a distinct pattern so that software can tell which region is frozen. A later resume continues the erase for the cycles it still had left. The active-low reset aborts any operation, and the block returns to plain array reads.

Addresses reach the block as sector indices, which are the address bits above the sector offset. A block is a group of `2**BLK_SHIFT` consecutive sectors.

Top module: `flash_status_unit`

## Requirements
- R1: With no operation running, a read (`rd_en` high at a clock edge) loads `array_data` into `rd_data` at that edge. `rd_data` keeps its value until the next read.
- R2: During a program, a read returns bit 7 equal to the complement of `prog_dq7` as captured at the start. The first read after the program finishes returns `array_data` unchanged.
- R3: During any erase, a read returns bit 7 = 0. After the erase finishes, reads return `array_data`.
- R4: During a program or an erase, bit 6 of each read inverts relative to the previous status read that toggled it. The first such read after reset returns 0.
- R5: Bit 2 holds its value during reads of a running program. It inverts on each read during an erase, and on each read of the suspended region.
- R6: In every status byte, bits 5, 4, 3, 1 and 0 are 0.
- R7: Each operation stays busy for exactly its configured number of clock edges after the start edge: program `PROG_CYC`, sector erase `SECT_CYC`, block erase `BLK_CYC`, chip erase `CHIP_CYC`.
- R8: Suspend is accepted during a sector or block erase. The erase keeps running and keeps reporting erase status for `SUSP_CYC` edges, then freezes. While frozen, a read of the suspended region returns bit 7 = 1, bit 6 = 1 and bit 2 toggling. Reads elsewhere return `array_data`.
- R9: Resume continues the erase for the cycles it still had left. Cycles spent suspended do not count.
- R10: While suspended, a program to a sector outside the suspended region runs and reports program status. Afterwards the block returns to the suspended state. A program that targets the suspended region is ignored.
- R11: Start, suspend and resume pulses that arrive while an operation is running are ignored. Suspend is ignored during a chip erase.
- R12: Reset clears `rd_data` to 0, aborts any operation, and clears both toggle bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; aborts operations |
| prog_start | input | 1 | One-cycle pulse starting a byte program |
| prog_sect | input | SIDX_W | Sector index of the byte being programmed |
| prog_dq7 | input | 1 | Bit 7 of the byte being programmed |
| sect_erase_start | input | 1 | One-cycle pulse starting a sector erase |
| blk_erase_start | input | 1 | One-cycle pulse starting a block erase |
| chip_erase_start | input | 1 | One-cycle pulse starting a chip erase |
| erase_sect | input | SIDX_W | Sector index selecting the erased sector or block |
| suspend_req | input | 1 | One-cycle erase suspend pulse |
| resume_req | input | 1 | One-cycle erase resume pulse |
| rd_en | input | 1 | Read strobe |
| rd_sect | input | SIDX_W | Sector index of the read address |
| array_data | input | 8 | Array contents at the read address |
| rd_data | output | 8 | Byte returned by the last read |

## Verification
The reporter is driven with short read bursts of each operation type. The bursts are placed on the first and last busy edges, so an off-by-one in any of the four durations shows up as a status byte where array data was expected, or the other way round. Program is tried with both values of the captured bit 7 to separate the complement from a constant. Erase bursts let the two toggle bits run side by side and expose a toggle tied to the wrong operation. The suspend sequence alternates reads inside and outside the frozen block, inserts an ignored and an accepted program, and times the resumed erase to its last edge. This separates a region-match error, a leaking resume and a timer that runs while frozen.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int BYTE_W   = 8;
    localparam int POLL_BIT = 7;
    localparam int TOG_BIT  = 6;
    localparam int TOG2_BIT = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_SPEND,
        ST_SUSP,
        ST_SPROG
    } fsr_state_e;

    typedef enum logic [1:0] {
        EK_SECT,
        EK_BLK,
        EK_CHIP
    } erase_kind_e;

    function automatic logic [BYTE_W-1:0] status_byte(input logic poll,
                                                      input logic tog,
                                                      input logic tog2);
        logic [BYTE_W-1:0] b;
        b           = '0;
        b[POLL_BIT] = poll;
        b[TOG_BIT]  = tog;
        b[TOG2_BIT] = tog2;
        return b;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fsr_timer.sv
module fsr_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // last running edge of the loaded interval
    assign expire = run && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/fsr_region_match.sv
module fsr_region_match
    import fsr_pkg::*;
#(
    parameter int SIDX_W    = 9,
    parameter int BLK_SHIFT = 4
) (
    input  logic [SIDX_W-1:0] probe,
    input  logic [SIDX_W-1:0] base,
    input  erase_kind_e       kind,
    output logic              hit
);
    logic sect_eq;
    logic blk_eq;

    assign sect_eq = (probe == base);
    assign blk_eq  = (probe[SIDX_W-1:BLK_SHIFT] == base[SIDX_W-1:BLK_SHIFT]);

    always_comb begin
        unique case (kind)
            EK_SECT: hit = sect_eq;
            EK_BLK:  hit = blk_eq;
            default: hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/fsr_status_mux.sv
module fsr_status_mux
    import fsr_pkg::*;
(
    input  fsr_state_e        st,
    input  logic              region_hit,
    input  logic              poll_src,
    input  logic              tog,
    input  logic              tog2,
    input  logic [BYTE_W-1:0] array_data,
    output logic [BYTE_W-1:0] rdata,
    output logic              flip_tog,
    output logic              flip_tog2
);
    always_comb begin
        rdata     = array_data;
        flip_tog  = 1'b0;
        flip_tog2 = 1'b0;
        unique case (st)
            ST_PROG, ST_SPROG: begin
                rdata    = status_byte(~poll_src, tog, tog2);
                flip_tog = 1'b1;
            end
            ST_ERASE, ST_SPEND: begin
                rdata     = status_byte(1'b0, tog, tog2);
                flip_tog  = 1'b1;
                flip_tog2 = 1'b1;
            end
            ST_SUSP: begin
                if (region_hit) begin
                    rdata     = status_byte(1'b1, 1'b1, tog2);
                    flip_tog2 = 1'b1;
                end
            end
            default: begin
                rdata = array_data;
            end
        endcase
    end

endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit
    import fsr_pkg::*;
#(
    parameter int SIDX_W    = 9,
    parameter int BLK_SHIFT = 4,
    parameter int PROG_CYC  = 6,
    parameter int SECT_CYC  = 20,
    parameter int BLK_CYC   = 24,
    parameter int CHIP_CYC  = 30,
    parameter int SUSP_CYC  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_start,
    input  logic [SIDX_W-1:0] prog_sect,
    input  logic              prog_dq7,
    input  logic              sect_erase_start,
    input  logic              blk_erase_start,
    input  logic              chip_erase_start,
    input  logic [SIDX_W-1:0] erase_sect,
    input  logic              suspend_req,
    input  logic              resume_req,
    input  logic              rd_en,
    input  logic [SIDX_W-1:0] rd_sect,
    input  logic [7:0]        array_data,
    output logic [7:0]        rd_data
);
    localparam int MAX_CYC = max_of(max_of(PROG_CYC, SUSP_CYC),
                                    max_of(max_of(SECT_CYC, BLK_CYC), CHIP_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        fsr_state_e        st;
        logic              pd7;
        erase_kind_e       ekind;
        logic [SIDX_W-1:0] esect;
        logic              tog;
        logic              tog2;
        logic [BYTE_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    fsr_state_e  st_q;
    logic        pd7_q;
    logic        rd_hit;
    logic        prog_hit;
    logic        prog_go, erase_go, susp_go, resume_go;
    logic        p_run, e_run, s_run;
    logic        p_exp, e_exp, s_exp;
    erase_kind_e new_kind;
    logic [CNT_W-1:0] erase_len;
    logic [BYTE_W-1:0] mux_data;
    logic        flip_tog, flip_tog2;

    assign st_q  = r_q.st;
    assign pd7_q = r_q.pd7;

    // region compare for the read probe and the program target
    fsr_region_match #(.SIDX_W(SIDX_W), .BLK_SHIFT(BLK_SHIFT)) i_rd_match (
        .probe(rd_sect), .base(r_q.esect), .kind(r_q.ekind), .hit(rd_hit)
    );
    fsr_region_match #(.SIDX_W(SIDX_W), .BLK_SHIFT(BLK_SHIFT)) i_pg_match (
        .probe(prog_sect), .base(r_q.esect), .kind(r_q.ekind), .hit(prog_hit)
    );

    // command acceptance
    always_comb begin
        prog_go   = prog_start && ((st_q == ST_IDLE) || ((st_q == ST_SUSP) && !prog_hit));
        erase_go  = (st_q == ST_IDLE) && !prog_start &&
                    (sect_erase_start || blk_erase_start || chip_erase_start);
        susp_go   = suspend_req && (st_q == ST_ERASE) && (r_q.ekind != EK_CHIP);
        resume_go = resume_req && (st_q == ST_SUSP) && !prog_go;
        if (sect_erase_start) begin
            new_kind  = EK_SECT;
            erase_len = CNT_W'(SECT_CYC);
        end else if (blk_erase_start) begin
            new_kind  = EK_BLK;
            erase_len = CNT_W'(BLK_CYC);
        end else begin
            new_kind  = EK_CHIP;
            erase_len = CNT_W'(CHIP_CYC);
        end
        p_run = (st_q == ST_PROG) || (st_q == ST_SPROG);
        e_run = (st_q == ST_ERASE) || (st_q == ST_SPEND);
        s_run = (st_q == ST_SPEND);
    end

    fsr_timer #(.CNT_W(CNT_W)) i_prog_tmr (
        .clk(clk), .rst_n(rst_n), .load(prog_go), .load_val(CNT_W'(PROG_CYC)),
        .run(p_run), .expire(p_exp)
    );
    fsr_timer #(.CNT_W(CNT_W)) i_erase_tmr (
        .clk(clk), .rst_n(rst_n), .load(erase_go), .load_val(erase_len),
        .run(e_run), .expire(e_exp)
    );
    fsr_timer #(.CNT_W(CNT_W)) i_susp_tmr (
        .clk(clk), .rst_n(rst_n), .load(susp_go), .load_val(CNT_W'(SUSP_CYC)),
        .run(s_run), .expire(s_exp)
    );

    fsr_status_mux i_mux (
        .st(st_q), .region_hit(rd_hit), .poll_src(r_q.pd7), .tog(r_q.tog),
        .tog2(r_q.tog2), .array_data(array_data), .rdata(mux_data),
        .flip_tog(flip_tog), .flip_tog2(flip_tog2)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (prog_go)       r_d.st = ST_PROG;
                else if (erase_go) r_d.st = ST_ERASE;
            end
            ST_PROG: begin
                if (p_exp) r_d.st = ST_IDLE;
            end
            ST_ERASE: begin
                if (e_exp)        r_d.st = ST_IDLE;
                else if (susp_go) r_d.st = ST_SPEND;
            end
            ST_SPEND: begin
                if (e_exp)      r_d.st = ST_IDLE;
                else if (s_exp) r_d.st = ST_SUSP;
            end
            ST_SUSP: begin
                if (prog_go)        r_d.st = ST_SPROG;
                else if (resume_go) r_d.st = ST_ERASE;
            end
            ST_SPROG: begin
                if (p_exp) r_d.st = ST_SUSP;
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (prog_go) begin
            r_d.pd7 = prog_dq7;
        end
        if (erase_go) begin
            r_d.ekind = new_kind;
            r_d.esect = erase_sect;
        end
        if (rd_en) begin
            r_d.rdata = mux_data;
            r_d.tog   = r_q.tog ^ flip_tog;
            r_d.tog2  = r_q.tog2 ^ flip_tog2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.pd7   <= 1'b0;
            r_q.ekind <= EK_SECT;
            r_q.esect <= '0;
            r_q.tog   <= 1'b0;
            r_q.tog2  <= 1'b0;
            r_q.rdata <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_data = r_q.rdata;

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
    import fsr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic [7:0] array_data,
    input fsr_state_e st,
    input logic       pd7,
    input logic       rd_hit,
    input logic       sect_erase_start,
    input logic       resume_req
);
    // R1
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && st == ST_IDLE) |=> rd_data == $past(array_data));

    // R2
    prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (st == ST_PROG || st == ST_SPROG)) |=> rd_data[7] != $past(pd7));

    // R3
    erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (st == ST_ERASE || st == ST_SPEND)) |=> rd_data[7] == 1'b0);

    // R6
    status_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && st != ST_IDLE && !(st == ST_SUSP && !rd_hit)) |=> (rd_data & 8'h3B) == 8'h00);

    // R8
    susp_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && st == ST_SUSP && rd_hit) |=> rd_data[7:6] == 2'b11);

    // R9
    frozen_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SUSP && !resume_req) |=> (st == ST_SUSP || st == ST_SPROG));

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG && sect_erase_start) |=> st != ST_ERASE);

endmodule

bind flash_status_unit fsr_checker i_fsr_checker (
    .clk(clk),
    .rst_n(rst_n),
    .rd_en(rd_en),
    .rd_data(rd_data),
    .array_data(array_data),
    .st(st_q),
    .pd7(pd7_q),
    .rd_hit(rd_hit),
    .sect_erase_start(sect_erase_start),
    .resume_req(resume_req)
);

// File: tb/test_flash_status_unit.sv
module test_flash_status_unit;
    localparam int CLK_PERIOD = 10;
    localparam int SIDX_W = 9;
    localparam int K_ARR = 0, K_PROG = 1, K_ERASE = 2, K_SUSREG = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_start = 1'b0, prog_dq7 = 1'b0;
    logic [SIDX_W-1:0] prog_sect = '0, erase_sect = '0, rd_sect = '0;
    logic sect_erase_start = 1'b0, blk_erase_start = 1'b0, chip_erase_start = 1'b0;
    logic suspend_req = 1'b0, resume_req = 1'b0, rd_en = 1'b0;
    logic [7:0] array_data = '0;
    logic [7:0] rd_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_status_unit #(
        .SIDX_W(SIDX_W), .BLK_SHIFT(4), .PROG_CYC(6), .SECT_CYC(20),
        .BLK_CYC(24), .CHIP_CYC(30), .SUSP_CYC(4)
    ) i_flash_status_unit (.*);

    typedef struct {
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sb[$];

    int n_tests = 0;
    int n_fail  = 0;
    logic m_tog = 1'b0, m_tog2 = 1'b0;
    logic mon_due = 1'b0;
    bit finished = 1'b0;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rd_data actual %02h expected %02h", req, act, exp);
        end
    endtask

    // driver: one clock edge per call, pushes expected byte
    task automatic rd(input logic [SIDX_W-1:0] s, input logic [7:0] arr,
                      input int kind, input logic pd7, input string req);
        item_t it;
        rd_en = 1'b1; rd_sect = s; array_data = arr;
        it.req = req;
        case (kind)
            K_PROG:  begin it.exp = {~pd7, m_tog, 3'b000, m_tog2, 2'b00}; m_tog = ~m_tog; end
            K_ERASE: begin it.exp = {1'b0, m_tog, 3'b000, m_tog2, 2'b00}; m_tog = ~m_tog; m_tog2 = ~m_tog2; end
            K_SUSREG: begin it.exp = {2'b11, 3'b000, m_tog2, 2'b00}; m_tog2 = ~m_tog2; end
            default: it.exp = arr;
        endcase
        sb.push_back(it);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_prog(input logic [SIDX_W-1:0] s, input logic d7);
        prog_start = 1'b1; prog_sect = s; prog_dq7 = d7;
        @(negedge clk);
        prog_start = 1'b0;
    endtask

    task automatic start_erase(input int kind, input logic [SIDX_W-1:0] s);
        erase_sect = s;
        sect_erase_start = (kind == 0);
        blk_erase_start  = (kind == 1);
        chip_erase_start = (kind == 2);
        @(negedge clk);
        sect_erase_start = 1'b0; blk_erase_start = 1'b0; chip_erase_start = 1'b0;
    endtask

    task automatic pulse_susp();
        suspend_req = 1'b1; @(negedge clk); suspend_req = 1'b0;
    endtask

    task automatic pulse_resume();
        resume_req = 1'b1; @(negedge clk); resume_req = 1'b0;
    endtask

    // monitor: compares one cycle after each read edge
    always @(posedge clk) mon_due <= rd_en;
    always @(negedge clk) begin
        if (mon_due) begin
            if (sb.size() == 0) begin
                n_tests++; n_fail++;
                $display("FAIL R1: unexpected read result actual %02h expected none", rd_data);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(it.req, rd_data, it.exp);
            end
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog (all R): actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        cyc(2);
        check("R12", rd_data, 8'h00);
        rst_n = 1'b1;
        cyc(1);

        // R1 idle reads
        rd(9'h001, 8'h3C, K_ARR, 1'b0, "R1");
        rd(9'h1FF, 8'hFF, K_ARR, 1'b0, "R1");
        rd(9'h080, 8'h00, K_ARR, 1'b0, "R1");

        // program with bit7 = 0: six busy edges
        start_prog(9'h100, 1'b0);
        rd(9'h100, 8'h11, K_PROG, 1'b0, "R2");
        rd(9'h100, 8'h11, K_PROG, 1'b0, "R2");
        rd(9'h100, 8'h11, K_PROG, 1'b0, "R4");
        rd(9'h100, 8'h11, K_PROG, 1'b0, "R5");
        rd(9'h100, 8'h11, K_PROG, 1'b0, "R4");
        rd(9'h100, 8'h11, K_PROG, 1'b0, "R6");
        rd(9'h100, 8'h5A, K_ARR, 1'b0, "R2");

        // program with bit7 = 1, boundary on last edge
        start_prog(9'h101, 1'b1);
        rd(9'h101, 8'hC3, K_PROG, 1'b1, "R2");
        cyc(4);
        rd(9'h101, 8'hC3, K_PROG, 1'b1, "R7");
        rd(9'h101, 8'hC3, K_ARR, 1'b1, "R7");

        // sector erase, program pulse inside ignored
        start_erase(0, 9'h030);
        rd(9'h030, 8'h00, K_ERASE, 1'b0, "R3");
        rd(9'h030, 8'h00, K_ERASE, 1'b0, "R5");
        rd(9'h031, 8'h00, K_ERASE, 1'b0, "R6");
        start_prog(9'h040, 1'b1);
        cyc(15);
        rd(9'h030, 8'h00, K_ERASE, 1'b0, "R7");
        rd(9'h030, 8'hFF, K_ARR, 1'b0, "R3");

        // block erase length
        start_erase(1, 9'h060);
        rd(9'h060, 8'h00, K_ERASE, 1'b0, "R3");
        cyc(22);
        rd(9'h060, 8'h00, K_ERASE, 1'b0, "R7");
        rd(9'h060, 8'hFF, K_ARR, 1'b0, "R7");

        // chip erase: suspend ignored
        start_erase(2, 9'h000);
        rd(9'h011, 8'h00, K_ERASE, 1'b0, "R3");
        pulse_susp();
        cyc(5);
        rd(9'h055, 8'h99, K_ERASE, 1'b0, "R11");
        cyc(21);
        rd(9'h055, 8'h00, K_ERASE, 1'b0, "R7");
        rd(9'h055, 8'hFF, K_ARR, 1'b0, "R7");

        // block erase with suspend, program, resume
        start_erase(1, 9'h125);
        rd(9'h12F, 8'h00, K_ERASE, 1'b0, "R3");
        rd(9'h12F, 8'h00, K_ERASE, 1'b0, "R3");
        pulse_susp();
        rd(9'h12F, 8'h00, K_ERASE, 1'b0, "R8");
        cyc(2);
        rd(9'h12F, 8'h00, K_ERASE, 1'b0, "R8");
        rd(9'h12F, 8'h21, K_SUSREG, 1'b0, "R8");
        rd(9'h010, 8'h77, K_ARR, 1'b0, "R8");
        rd(9'h120, 8'h21, K_SUSREG, 1'b0, "R5");
        start_prog(9'h120, 1'b0);
        rd(9'h12F, 8'h21, K_SUSREG, 1'b0, "R10");
        start_prog(9'h020, 1'b0);
        rd(9'h12F, 8'h21, K_PROG, 1'b0, "R10");
        pulse_resume();
        cyc(3);
        rd(9'h12F, 8'h21, K_PROG, 1'b0, "R10");
        rd(9'h12A, 8'h21, K_SUSREG, 1'b0, "R11");
        pulse_resume();
        rd(9'h12F, 8'h00, K_ERASE, 1'b0, "R9");
        cyc(15);
        rd(9'h12F, 8'h00, K_ERASE, 1'b0, "R9");
        rd(9'h12F, 8'hFF, K_ARR, 1'b0, "R9");

        // reset aborts erase and clears toggles
        start_erase(0, 9'h002);
        rd(9'h002, 8'h00, K_ERASE, 1'b0, "R3");
        rst_n = 1'b0;
        @(negedge clk);
        check("R12", rd_data, 8'h00);
        rst_n = 1'b1;
        m_tog = 1'b0; m_tog2 = 1'b0;
        rd(9'h002, 8'h42, K_ARR, 1'b0, "R12");
        start_prog(9'h003, 1'b1);
        rd(9'h003, 8'h00, K_PROG, 1'b1, "R12");
        cyc(8);

        if (sb.size() != 0) begin
            n_tests++; n_fail++;
            $display("FAIL R1: pending reads actual %0d expected 0", sb.size());
        end
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule